// File: doc/BRIEF.md
# Multicycle Two-Register Accumulator Core

This block is a small processor core that runs programs from a single 64-word memory holding both code and data. Every instruction has the same 12-bit layout: a 4-bit operation code, one bit choosing one of two 8-bit working registers, and a 6-bit direct memory address. Each instruction passes through a fixed sequence of states: fetch, decode, memory access, execute and write-back. Every instruction except halt therefore spends exactly five clock cycles and presents one address to memory during its memory-access state.

Arithmetic and logic operations combine the chosen register with the memory word at the address. The unary operations act on the register alone. Loads and stores move data between a register and memory. Control flow offers an unconditional jump, a jump-and-link that saves the return address in a hidden link register, a jump through that link register, and jumps taken when the register is positive or when it is zero. A halt instruction freezes the core and raises a status output.

The core drives one synchronous memory port. The memory returns read data one cycle after the address. A write takes effect at the clock edge where the write enable is high.

Top module: `regcore_cpu`

## Requirements
- R1: While `rst_n` is low at a clock edge, the program counter, both working registers and the link register clear to zero, `halted` is low, and the first fetch presents address 0.
- R2: Instruction word bits [11:8] are the operation code, bit [7] selects the register (0 or 1), bit [6] is unused and bits [5:0] are the address. Data is taken from bits [7:0] of a memory word, and bits [11:8] of a data word are ignored.
- R3: Codes 0x0 (add), 0x1 (subtract), 0x2 (AND), 0x3 (XOR) and 0x7 (OR) combine the register with the data at the address and write the result to that register. Add and subtract wrap modulo 256.
- R4: Codes 0x4 (invert), 0x5 (shift left by one) and 0x6 (shift right by one) act on the register in place. Both shifts fill with zero, and the address field has no effect on the result.
- R5: Code 0x8 loads the data at the address into the register. Code 0x9 writes the register to the address as {4'b0000, reg}, with `mem_we` high for exactly one cycle.
- R6: An instruction changes only the register its select bit names. The other register keeps its value.
- R7: Code 0xC jumps to the address. Code 0xD jumps to the address and saves PC+1 in the link register. Code 0xB jumps to the address held in the link register.
- R8: Code 0xE jumps when the register is positive (bit 7 clear and value non-zero). Code 0xF jumps when the register is zero. If the condition fails, execution continues at PC+1.
- R9: Code 0xA raises `halted`, which then stays high until reset. Once halted, the core issues no further writes and holds `mem_addr` steady.
- R10: Each non-halt instruction takes exactly five cycles: fetch, decode, memory access, execute and write-back. A halt reaches the halted state two cycles after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 6 | Memory word address |
| mem_wdata | output | 12 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 12 | Memory read data, valid one cycle after the address |
| halted | output | 1 | High once a halt instruction has been decoded |

## Verification
The bench runs one program and observes every store. The stores cover adding 0xFF to 0x01, which must wrap to zero, and a shift right of a value with bit 7 set, which must fill with zero. They also cover an OR with a data word whose upper nibble is set; a core that used the whole word would give the wrong result. Two conditional tests are easy to get wrong: a negative value and a zero value must not satisfy "positive", and a non-zero value must not satisfy "zero". A wrong core takes those branches into a trap store at address 63. A jump-and-link to a subroutine that returns through the link register must resume at the instruction after the call; saving the wrong address either repeats the call or skips the next store. The bench also counts cycles up to the halt and confirms that nothing is written after it. This exposes extra or missing states and writes after the halt.

// File: rtl/regcore_pkg.sv
// Shared types for the two-register accumulator core.
// Assumes a fixed 4-bit operation code and a single register-select bit.
package regcore_pkg;

    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_AND  = 4'h2,
        OP_XOR  = 4'h3,
        OP_INV  = 4'h4,
        OP_SHL  = 4'h5,
        OP_SHR  = 4'h6,
        OP_OR   = 4'h7,
        OP_LOAD = 4'h8,
        OP_STOR = 4'h9,
        OP_HALT = 4'hA,
        OP_RETL = 4'hB,
        OP_JUMP = 4'hC,
        OP_CALL = 4'hD,
        OP_JPOS = 4'hE,
        OP_JZER = 4'hF
    } op_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_MEM,
        ST_EXEC,
        ST_WB,
        ST_HALT
    } state_e;

    // True for operations whose result goes back into the selected register.
    function automatic logic op_writes_reg(op_e op);
        return (op inside {OP_ADD, OP_SUB, OP_AND, OP_XOR, OP_INV,
                           OP_SHL, OP_SHR, OP_OR, OP_LOAD});
    endfunction

endpackage

// File: rtl/regcore_alu.sv
// Combinational ALU: combines register value a with memory data b.
// Assumes non-arithmetic codes pass a through unchanged. Flags are not produced.
module regcore_alu
    import regcore_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);

    // Select the result for the current operation.
    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_XOR:  y = a ^ b;
            OP_OR:   y = a | b;
            OP_INV:  y = ~a;
            OP_SHL:  y = {a[DW-2:0], 1'b0};
            OP_SHR:  y = {1'b0, a[DW-1:1]};
            OP_LOAD: y = b;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/regcore_regfile.sv
// Working register bank with one write port and one read port.
// Assumes write and read use the same select during any instruction.
module regcore_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 2,
    localparam int SW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] regs [NREG];

    // One storage register per slot, cleared on reset.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && (int'(sel) == g))
                regs[g] <= wdata;
        end
    end

    // Read the selected register.
    assign rdata = regs[sel];

endmodule

// File: rtl/regcore_branch.sv
// Next program counter and link-save decision for the write-back state.
// Assumes a is the selected register, two's complement.
module regcore_branch
    import regcore_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 6
) (
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] target,
    input  logic [AW-1:0] link,
    output logic [AW-1:0] next_pc,
    output logic [AW-1:0] ret_pc,
    output logic          link_we
);

    logic is_zero;
    logic is_pos;

    // Condition flags from the register value.
    assign is_zero = (a == '0);
    assign is_pos  = !a[DW-1] && !is_zero;
    assign ret_pc  = pc + AW'(1);

    // Pick the next PC and decide whether to save the return address.
    always_comb begin
        link_we = 1'b0;
        unique case (op)
            OP_JUMP: next_pc = target;
            OP_CALL: begin
                next_pc = target;
                link_we = 1'b1;
            end
            OP_RETL: next_pc = link;
            OP_JPOS: next_pc = is_pos  ? target : ret_pc;
            OP_JZER: next_pc = is_zero ? target : ret_pc;
            default: next_pc = ret_pc;
        endcase
    end

endmodule

// File: rtl/regcore_cpu.sv
// Top level: multicycle two-register core with one synchronous memory port.
// Assumes memory read data is valid one cycle after mem_addr, and that writes
// land at the edge where mem_we is high.
module regcore_cpu
    import regcore_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 6,
    localparam int IW = OPW + 2 + AW
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic [IW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [IW-1:0] mem_rdata,
    output logic          halted
);

    state_e        state;
    logic [AW-1:0] pc;
    logic [AW-1:0] link;
    op_e           ir_op;
    logic          ir_sel;
    logic [AW-1:0] ir_addr;
    logic [DW-1:0] res_q;
    logic [DW-1:0] rd_val;
    logic [DW-1:0] alu_y;
    logic [AW-1:0] next_pc;
    logic [AW-1:0] ret_pc;
    logic          link_we;
    logic          reg_we;

    // Register bank write happens in write-back only.
    assign reg_we = (state == ST_WB) && op_writes_reg(ir_op);

    regcore_regfile #(.DW(DW), .NREG(2)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .sel   (ir_sel),
        .wdata (res_q),
        .rdata (rd_val)
    );

    regcore_alu #(.DW(DW)) u_alu (
        .op (ir_op),
        .a  (rd_val),
        .b  (mem_rdata[DW-1:0]),
        .y  (alu_y)
    );

    regcore_branch #(.DW(DW), .AW(AW)) u_br (
        .op      (ir_op),
        .a       (rd_val),
        .pc      (pc),
        .target  (ir_addr),
        .link    (link),
        .next_pc (next_pc),
        .ret_pc  (ret_pc),
        .link_we (link_we)
    );

    // Sequencer: walks fetch, decode, memory, execute and write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_FETCH;
            pc      <= '0;
            link    <= '0;
            ir_op   <= OP_ADD;
            ir_sel  <= 1'b0;
            ir_addr <= '0;
            res_q   <= '0;
        end else begin
            unique case (state)
                ST_FETCH:  state <= ST_DECODE;
                ST_DECODE: begin
                    ir_op   <= op_e'(mem_rdata[IW-1 -: OPW]);
                    ir_sel  <= mem_rdata[AW+1];
                    ir_addr <= mem_rdata[AW-1:0];
                    state   <= (op_e'(mem_rdata[IW-1 -: OPW]) == OP_HALT)
                               ? ST_HALT : ST_MEM;
                end
                ST_MEM:    state <= ST_EXEC;
                ST_EXEC: begin
                    res_q <= alu_y;
                    state <= ST_WB;
                end
                ST_WB: begin
                    pc <= next_pc;
                    if (link_we)
                        link <= ret_pc;
                    state <= ST_FETCH;
                end
                default:   state <= ST_HALT;
            endcase
        end
    end

    // Memory port: PC during fetch, operand address otherwise.
    assign mem_addr  = (state == ST_FETCH) ? pc : ir_addr;
    assign mem_we    = (state == ST_MEM) && (ir_op == OP_STOR);
    assign mem_wdata = {{(IW-DW){1'b0}}, rd_val};
    assign halted    = (state == ST_HALT);

endmodule

// File: rtl/regcore_cpu_chk.sv
// Property checker for regcore_cpu, attached by bind below.
// Assumes access to the core's state and program counter.
module regcore_cpu_chk
    import regcore_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          halted,
    input state_e        state,
    input logic [AW-1:0] pc
);

    // R1: reset clears the PC and the halted flag
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (pc == '0) && !halted && (state == ST_FETCH));

    // R9: halted stays high until reset
    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R9: no write while halted
    a_r9_no_write_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    // R9: address frozen while halted
    a_r9_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(mem_addr));

    // R5: a store pulses the write enable for one cycle only
    a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R10: write-back always returns to fetch
    a_r10_wb_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WB) |=> (state == ST_FETCH));

    // R10: the PC only moves in write-back
    a_r10_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_WB) |=> $stable(pc));

endmodule

bind regcore_cpu regcore_cpu_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .halted   (halted),
    .state    (state),
    .pc       (pc)
);

// File: tb/tb_regcore_cpu.sv
// Scoreboard bench: a driver task queues the expected stores, and a monitor
// compares each write the core makes against the head of the queue.
module tb_regcore_cpu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  mem_addr;
    logic [11:0] mem_wdata;
    logic        mem_we;
    logic [11:0] mem_rdata;
    logic        halted;

    int n_tests = 0;
    int n_fail  = 0;

    logic [11:0] mem [64];
    logic [5:0]  exp_a [$];
    logic [7:0]  exp_d [$];
    string       exp_t [$];

    always #10 clk = ~clk;

    regcore_cpu dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    // Synchronous memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    function automatic logic [11:0] enc(input logic [3:0] op, input logic sel,
                                        input logic [5:0] a);
        return {op, sel, 1'b0, a};
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_store(input logic [5:0] a, input logic [7:0] d,
                                input string req);
        exp_a.push_back(a);
        exp_d.push_back(d);
        exp_t.push_back(req);
    endtask

    // Monitor: compare every write with the queued expectation.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_a.size() == 0) begin
                check("R8 stray store addr", {26'd0, mem_addr}, 32'hFFFF);
            end else begin
                string t;
                logic [5:0] a;
                logic [7:0] d;
                t = exp_t.pop_front();
                a = exp_a.pop_front();
                d = exp_d.pop_front();
                check({t, " addr"}, {26'd0, mem_addr}, {26'd0, a});
                check({t, " data"}, {20'd0, mem_wdata}, {24'd0, d});
            end
        end
    end

    initial begin
        int cyc;
        logic [5:0] frozen;
        for (int i = 0; i < 64; i++) mem[i] = 12'h000;
        // data (R2: upper nibble of word 44 must be ignored)
        mem[40] = 12'h05A; mem[41] = 12'h033; mem[42] = 12'h0FF;
        mem[43] = 12'h001; mem[44] = 12'hF80; mem[45] = 12'h000;
        // program
        mem[0]  = enc(4'h8, 0, 40);  // load r0 <- 5A
        mem[1]  = enc(4'h0, 0, 41);  // add  -> 8D
        mem[2]  = enc(4'h9, 0, 48);
        mem[3]  = enc(4'h8, 1, 42);  // r1 <- FF
        mem[4]  = enc(4'h0, 1, 43);  // wrap -> 00
        mem[5]  = enc(4'h9, 1, 49);
        mem[6]  = enc(4'h8, 0, 40);
        mem[7]  = enc(4'h1, 0, 41);  // sub -> 27
        mem[8]  = enc(4'h9, 0, 50);
        mem[9]  = enc(4'h8, 0, 40);
        mem[10] = enc(4'h2, 0, 41);  // and -> 12
        mem[11] = enc(4'h3, 0, 41);  // xor -> 21
        mem[12] = enc(4'h7, 0, 44);  // or  -> A1
        mem[13] = enc(4'h9, 0, 51);
        mem[14] = enc(4'h4, 0, 63);  // invert -> 5E, address ignored
        mem[15] = enc(4'h5, 0, 41);  // shl -> BC
        mem[16] = enc(4'h9, 0, 52);
        mem[17] = enc(4'h6, 0, 42);  // shr -> 5E, zero fill
        mem[18] = enc(4'h9, 0, 53);
        mem[19] = enc(4'h9, 1, 54);  // r1 still 00
        mem[20] = enc(4'hD, 0, 37);  // call, link = 21
        mem[21] = enc(4'hF, 1, 24);  // r1=01: zero test not taken
        mem[22] = enc(4'h9, 1, 55);
        mem[23] = enc(4'hE, 1, 26);  // r1=01 positive: taken
        mem[24] = enc(4'h9, 0, 63);  // trap
        mem[25] = enc(4'h9, 0, 63);  // trap
        mem[26] = enc(4'h8, 0, 42);  // r0 = FF
        mem[27] = enc(4'hE, 0, 24);  // negative: not taken
        mem[28] = enc(4'hF, 0, 24);  // non-zero: not taken
        mem[29] = enc(4'h8, 0, 45);  // r0 = 00
        mem[30] = enc(4'hE, 0, 24);  // zero is not positive
        mem[31] = enc(4'hF, 0, 33);  // zero: taken
        mem[32] = enc(4'h9, 0, 63);  // trap
        mem[33] = enc(4'hC, 0, 35);  // jump
        mem[34] = enc(4'h9, 0, 63);  // trap
        mem[35] = enc(4'h9, 0, 57);
        mem[36] = enc(4'hA, 0, 0);   // halt
        mem[37] = enc(4'h8, 1, 43);  // subroutine: r1 = 01
        mem[38] = enc(4'h9, 1, 56);
        mem[39] = enc(4'hB, 0, 0);   // return through link

        expect_store(48, 8'h8D, "R3 add");
        expect_store(49, 8'h00, "R3 add wrap");
        expect_store(50, 8'h27, "R3 sub");
        expect_store(51, 8'hA1, "R2 or low byte");
        expect_store(52, 8'hBC, "R4 invert+shl");
        expect_store(53, 8'h5E, "R4 shr zero fill");
        expect_store(54, 8'h00, "R6 other reg kept");
        expect_store(56, 8'h01, "R7 call target");
        expect_store(55, 8'h01, "R7 link return");
        expect_store(57, 8'h00, "R8 cond jumps");

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 halted low", {31'd0, halted}, 0);
        check("R1 fetch addr", {26'd0, mem_addr}, 0);
        check("R1 no write", {31'd0, mem_we}, 0);
        rst_n = 1'b1;

        cyc = 0;
        while (!halted && cyc < 5000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        if (cyc >= 5000) check("R10 watchdog", 1, 0);
        check("R10 cycles to halt", cyc, 177);
        check("R9 halted", {31'd0, halted}, 1);
        frozen = mem_addr;
        repeat (20) @(negedge clk);
        check("R9 halted stays", {31'd0, halted}, 1);
        check("R9 addr frozen", {26'd0, mem_addr}, {26'd0, frozen});
        check("R5 pending stores", exp_a.size(), 0);
        check("R8 trap untouched", {20'd0, mem[63]}, 0);
        check("R5 store word", {20'd0, mem[48]}, 32'h08D);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule